// File: doc/BRIEF.md
# Pulse-Width Test Mode Selector

This block selects a manufacturing test mode from the width of a low pulse on a reset strobe. While power-good is high, it counts reference clock cycles during which the strobe is held low. When the strobe returns high, the block decodes the measured width into a mode code. Some widths select a test mode. Some mean normal operation. Some are reserved.

A selected code is applied a fixed number of clocks later on registered outputs:
- a 4-bit mode code;
- a one-hot enable for the all-outputs-high-impedance mode;
- one-hot enables for the nine XOR-chain style modes;
- an active flag.

Sending another pulse moves the block to another mode. A pulse whose width means "no mode" brings the chip back to normal operation.

The strobe is asynchronous and passes through a synchronizer. Power-good and the platform reset are synchronous to the clock. The block has no streaming data path, so every pin is a plain level or pulse.

Top module: `pw_test_mode_sel`

## Requirements
- R1: Low cycles are counted only when all of the following hold:
  - power-good is high;
  - the synchronized strobe is low;
  - the strobe has been seen high at least once since the platform reset was released.
- R2: The width is judged only when the synchronized strobe rises. Widths 4,5,6,7,8 give codes 1..5. Width 14 gives 6, 52 gives 7, 53 gives 8, 59 gives 9 and 60 gives 10.
- R3: A decoded code reaches the outputs on the fifth rising edge, counting as the first the edge at which `strobe_n` is first sampled high. This is two synchronizer stages plus three delay clocks.
- R4: Widths below 4, from 9 to 13, and above 60 apply code 0, which is normal operation.
- R5: Widths 15..51 and 54..58 are reserved. They leave the mode unchanged. `rsvd_err` is high for exactly one cycle, following the third rising edge after release.
- R6: The enables follow the applied code:
  - `hiz_en` is high only for code 10;
  - `xor_en[i]` is high only for code i+1 (i = 0..8);
  - `active` is high for any nonzero code.
- R7: The width counter saturates at 61, so any longer pulse still decodes as "above 60".
- R8: When power-good is low at a clock edge, that edge forces code 0 and discards both the count and any pending code.
- R9: `rst_n` low clears all outputs. A strobe held low across reset release is not accepted as a pulse.
- R10: A later pulse replaces the current mode with the newly decoded one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Platform reset, active low, asynchronous assert |
| pwr_good | input | 1 | Power-good level, synchronous |
| strobe_n | input | 1 | Active-low selection strobe, asynchronous |
| mode_code | output | 4 | Applied test mode code, 0 = normal |
| hiz_en | output | 1 | All-outputs-high-impedance enable |
| xor_en | output | 9 | One-hot XOR-chain mode enables |
| active | output | 1 | Any test mode applied |
| rsvd_err | output | 1 | One-cycle flag for a reserved width |

## Verification
A power-good drop can land on the very edge at which a pending code would be applied. The bench provokes this by dropping power-good right after the fourth edge following release. It expects code 0 on the fifth edge and no late application afterward.

A reserved pulse can also raise `rsvd_err` while an earlier mode is current. The vector table interleaves reserved widths between valid ones, so the bench checks both the flag and the unchanged code.

// File: rtl/tms_pkg.sv
package tms_pkg;
  localparam int CODE_W = 4;
  localparam int N_XOR  = 9;
  localparam int CODE_HIZ = 10;

  typedef enum logic [1:0] {DEC_NONE, DEC_MODE, DEC_RSVD} dec_kind_e;

  typedef struct packed {
    dec_kind_e          kind;
    logic [CODE_W-1:0]  code;
  } dec_t;

  // Width-to-mode mapping; unlisted widths inside the test band are reserved.
  function automatic dec_t decode_width(input int unsigned w);
    dec_t d;
    d.kind = DEC_NONE;
    d.code = '0;
    if (w >= 4 && w <= 8) begin
      d.kind = DEC_MODE;
      d.code = CODE_W'(w - 3);
    end else if (w == 14) begin
      d.kind = DEC_MODE; d.code = CODE_W'(6);
    end else if (w == 52) begin
      d.kind = DEC_MODE; d.code = CODE_W'(7);
    end else if (w == 53) begin
      d.kind = DEC_MODE; d.code = CODE_W'(8);
    end else if (w == 59) begin
      d.kind = DEC_MODE; d.code = CODE_W'(9);
    end else if (w == 60) begin
      d.kind = DEC_MODE; d.code = CODE_W'(CODE_HIZ);
    end else if (w >= 15 && w <= 58) begin
      d.kind = DEC_RSVD;
    end
    return d;
  endfunction
endpackage

// File: rtl/tms_sync.sv
module tms_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] ff;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) ff <= '0;
        else        ff <= d;
    end else begin : g_many
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) ff <= '0;
        else        ff <= {ff[STAGES-2:0], d};
    end
  endgenerate

  assign q = ff[STAGES-1];
endmodule

// File: rtl/tms_pulse_counter.sv
module tms_pulse_counter #(
  parameter int CNT_MAX = 61,
  localparam int CW = $clog2(CNT_MAX + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pwr_good,
  input  logic          strobe_s,
  output logic [CW-1:0] count,
  output logic          release_o
);
  logic strobe_q;
  logic armed;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      strobe_q <= 1'b0;
      armed    <= 1'b0;
      count    <= '0;
    end else begin
      strobe_q <= strobe_s;
      armed    <= armed | strobe_s;
      if (!pwr_good || strobe_s)
        count <= '0;
      else if (armed && count != CW'(CNT_MAX))
        count <= count + 1'b1;
    end
  end

  assign release_o = strobe_s & ~strobe_q & armed & pwr_good;

  p_cnt_sat_r7: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(CNT_MAX));
  p_cnt_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_good && !strobe_s && armed && count == CW'(CNT_MAX)) |=> count == CW'(CNT_MAX));
  p_cnt_pg_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !pwr_good |=> count == '0);
  p_cnt_unarmed_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!armed && !strobe_s) |=> count == '0);
endmodule

// File: rtl/tms_range_decode.sv
module tms_range_decode
  import tms_pkg::*;
#(
  parameter int CW = 6
) (
  input  logic [CW-1:0] count,
  output dec_t          dec
);
  always_comb dec = decode_width(int'(count));
endmodule

// File: rtl/tms_mode_latch.sv
module tms_mode_latch
  import tms_pkg::*;
#(
  parameter int LAT_CLKS = 3,
  localparam int DW = $clog2(LAT_CLKS + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pwr_good,
  input  logic              release_i,
  input  dec_t              dec_i,
  output logic [CODE_W-1:0] mode_code,
  output logic              hiz_en,
  output logic [N_XOR-1:0]  xor_en,
  output logic              active,
  output logic              rsvd_err
);
  logic              pend;
  logic [CODE_W-1:0] pend_code;
  logic [DW-1:0]     dly;

  // LAT_CLKS counts from the cycle the synchronized release is seen; minimum 2.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend      <= 1'b0;
      pend_code <= '0;
      dly       <= '0;
      mode_code <= '0;
      hiz_en    <= 1'b0;
      xor_en    <= '0;
      active    <= 1'b0;
      rsvd_err  <= 1'b0;
    end else begin
      rsvd_err <= 1'b0;
      if (!pwr_good) begin
        pend      <= 1'b0;
        mode_code <= '0;
        hiz_en    <= 1'b0;
        xor_en    <= '0;
        active    <= 1'b0;
      end else if (release_i) begin
        if (dec_i.kind == DEC_RSVD) begin
          rsvd_err <= 1'b1;
        end else begin
          pend      <= 1'b1;
          pend_code <= (dec_i.kind == DEC_MODE) ? dec_i.code : '0;
          dly       <= DW'(LAT_CLKS - 1);
        end
      end else if (pend) begin
        if (dly == DW'(1)) begin
          pend      <= 1'b0;
          mode_code <= pend_code;
          hiz_en    <= (pend_code == CODE_W'(CODE_HIZ));
          active    <= (pend_code != '0);
          for (int i = 0; i < N_XOR; i++)
            xor_en[i] <= (pend_code == CODE_W'(i + 1));
        end else begin
          dly <= dly - 1'b1;
        end
      end
    end
  end

  p_onehot_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({hiz_en, xor_en}));
  p_active_r6: assert property (@(posedge clk) disable iff (!rst_n)
    active == (|{hiz_en, xor_en}));
  p_pg_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !pwr_good |=> (mode_code == '0 && !active && !pend));
  p_err_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rsvd_err |=> !rsvd_err);
  p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!pend && pwr_good) |=> $stable(mode_code));
endmodule

// File: rtl/pw_test_mode_sel.sv
module pw_test_mode_sel
  import tms_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int CNT_MAX     = 61,
  parameter int LAT_CLKS    = 3,
  localparam int CW = $clog2(CNT_MAX + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pwr_good,
  input  logic              strobe_n,
  output logic [CODE_W-1:0] mode_code,
  output logic              hiz_en,
  output logic [N_XOR-1:0]  xor_en,
  output logic              active,
  output logic              rsvd_err
);
  logic          strobe_s;
  logic [CW-1:0] width;
  logic          rel;
  dec_t          dec;

  tms_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(strobe_n), .q(strobe_s)
  );

  tms_pulse_counter #(.CNT_MAX(CNT_MAX)) u_cnt (
    .clk(clk), .rst_n(rst_n), .pwr_good(pwr_good), .strobe_s(strobe_s),
    .count(width), .release_o(rel)
  );

  tms_range_decode #(.CW(CW)) u_dec (
    .count(width), .dec(dec)
  );

  tms_mode_latch #(.LAT_CLKS(LAT_CLKS)) u_latch (
    .clk(clk), .rst_n(rst_n), .pwr_good(pwr_good), .release_i(rel),
    .dec_i(dec), .mode_code(mode_code), .hiz_en(hiz_en), .xor_en(xor_en),
    .active(active), .rsvd_err(rsvd_err)
  );
endmodule

// File: tb/sim_pw_test_mode_sel.sv
module sim_pw_test_mode_sel;
  localparam int CLK_P = 10;
  localparam int NV = 20;
  // width, expected code, reserved flag
  localparam int  V_W[NV]   = '{4, 15, 8, 3, 14, 42, 52, 51, 53, 9, 59, 56, 60, 13, 5, 61, 6, 70, 7, 54};
  localparam int  V_C[NV]   = '{1,  0, 5, 0,  6,  0,  7,  0,  8, 0,  9,  0, 10,  0, 2,  0, 3,  0, 4,  0};
  localparam bit  V_R[NV]   = '{0,  1, 0, 0,  0,  1,  0,  1,  0, 0,  0,  1,  0,  0, 0,  0, 0,  0, 0,  1};

  logic clk = 1'b0, rst_n = 1'b0, pwr_good = 1'b0, strobe_n = 1'b0;
  logic [3:0] mode_code;
  logic hiz_en, active, rsvd_err;
  logic [8:0] xor_en;
  int checks = 0, errors = 0;
  bit done = 0;
  int cur = 0;

  pw_test_mode_sel u0 (
    .clk(clk), .rst_n(rst_n), .pwr_good(pwr_good), .strobe_n(strobe_n),
    .mode_code(mode_code), .hiz_en(hiz_en), .xor_en(xor_en),
    .active(active), .rsvd_err(rsvd_err)
  );

  always #(CLK_P/2) clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic check_mode(input int code, input string req);
    logic [8:0] ex;
    ex = (code >= 1 && code <= 9) ? (9'd1 << (code - 1)) : 9'd0;
    chk(mode_code == 4'(code), {req, " mode_code"}, mode_code, code);
    chk(hiz_en == (code == 10), "R6 hiz_en", hiz_en, code == 10);
    chk(xor_en == ex, "R6 xor_en", xor_en, ex);
    chk(active == (code != 0), "R6 active", active, code != 0);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  // Full pulse with checks at edges 3, 4 and 5 after release.
  task automatic run_pulse(input int w, input int nextc, input bit rsv, input string req);
    @(negedge clk) strobe_n = 1'b0;
    repeat (w) @(posedge clk);
    @(negedge clk) strobe_n = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(rsvd_err == rsv, "R5 rsvd_err at third edge", rsvd_err, rsv);
    check_mode(cur, "R3 before apply");
    @(posedge clk); @(negedge clk);
    chk(rsvd_err == 1'b0, "R5 rsvd_err single cycle", rsvd_err, 0);
    check_mode(cur, "R3 before apply");
    @(posedge clk); @(negedge clk);
    if (!rsv) cur = nextc;
    check_mode(cur, req);
    repeat (3) @(posedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    finish_run();
  end

  initial begin
    pwr_good = 1'b1;
    strobe_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check_mode(0, "R9 reset");
    chk(rsvd_err == 0, "R9 reset rsvd_err", rsvd_err, 0);
    rst_n = 1'b1;
    // R9: strobe held low across reset release is not a pulse
    repeat (5) @(posedge clk);
    @(negedge clk) strobe_n = 1'b1;
    repeat (8) @(posedge clk);
    @(negedge clk);
    check_mode(0, "R9 R1 strobe low across reset");
    chk(rsvd_err == 0, "R9 no error", rsvd_err, 0);

    // R2 R4 R5 R7 R10: vector table
    for (int i = 0; i < NV; i++)
      run_pulse(V_W[i], V_C[i], V_R[i], "R2 R4 R7 R10 table");

    // R8: power-good drop clears an active mode
    run_pulse(5, 2, 0, "R2 setup");
    @(negedge clk) pwr_good = 1'b0;
    @(posedge clk); @(negedge clk);
    cur = 0;
    check_mode(0, "R8 pg drop");
    pwr_good = 1'b1;
    repeat (3) @(posedge clk);

    // R8 same-edge race: pg falls on the edge a code would apply
    @(negedge clk) strobe_n = 1'b0;
    repeat (4) @(posedge clk);
    @(negedge clk) strobe_n = 1'b1;
    repeat (4) @(posedge clk);
    @(negedge clk) pwr_good = 1'b0;
    @(posedge clk); @(negedge clk);
    check_mode(0, "R8 pg wins apply edge");
    pwr_good = 1'b1;
    repeat (6) @(posedge clk);
    @(negedge clk);
    check_mode(0, "R8 pending discarded");

    // R1: pulse while power-good low is not counted
    @(negedge clk) begin pwr_good = 1'b0; strobe_n = 1'b0; end
    repeat (6) @(posedge clk);
    @(negedge clk) strobe_n = 1'b1;
    repeat (4) @(posedge clk);
    @(negedge clk) pwr_good = 1'b1;
    repeat (8) @(posedge clk);
    @(negedge clk);
    check_mode(0, "R1 pulse with pg low");

    // R9: reset clears an active mode
    run_pulse(60, 10, 0, "R6 hiz mode");
    @(negedge clk) rst_n = 1'b0;
    @(negedge clk);
    cur = 0;
    check_mode(0, "R9 reset clears");
    finish_run();
  end
endmodule